// File: doc/BRIEF.md
# Bus-Master DMA Channel Status Block

This block keeps the per-channel command and status state of a legacy disk DMA engine with two channels, primary and secondary. Software reaches it through a small byte-addressed register window. Each channel has three registers:

- a command register holding the start/stop bit;
- a status register with the active flag, the bus error flag, the device interrupt flag and two capability storage bits;
- a descriptor table base pointer.

The DMA data mover sits outside this block and supplies three kinds of input: an end-of-region pulse, pulses for bus errors (target abort, master abort, parity), and the raw interrupt line of the attached device for each channel. Each channel drives its own interrupt output, which follows that channel's interrupt flag.

The interrupt flag captures a rising edge of the device line, not its level. If software clears the flag while the line is still high, the flag stays clear until the line drops and rises again. The active flag can be cleared in two ways: by the engine finishing a region, or by software writing the start bit to 0.

Top module: `bmide_status_block`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and both interrupt outputs are 0.
- R2: A write with data bit 0 = 1 to the command register (byte offset 0) sets the command bit and the active flag (status bit 0) on the next cycle. If the region-done pulse arrives in the same cycle, the write still wins.
- R3: The active flag clears on the cycle after a region-done pulse. It also clears after a command write with data bit 0 = 0.
- R4: The error flag (status bit 1) sets on the cycle after any target abort, master abort or parity pulse. A status write with data bit 1 = 1 clears it. If an error pulse and the clearing write arrive in the same cycle, the flag stays set.
- R5: The interrupt flag (status bit 2) sets on the cycle after the device line goes from 0 to 1. A status write with data bit 2 = 1 clears it. The channel's interrupt output equals this flag.
- R6: If the interrupt flag is cleared while the line stays high, it remains 0 until the line falls and rises again.
- R7: Writing 0 to status bits 1 or 2 changes nothing. A status write never changes the active flag.
- R8: Status bits 6:5 are plain read/write storage. Bits 7, 4 and 3 always read 0.
- R9: The descriptor base register (byte offset 4) stores data bits 31:2. Its bits 1:0 always read 0.
- R10: Offsets 0, 2 and 4 select the command, status and base registers. Address bit 3 selects the channel (0 primary, 1 secondary). Unmapped offsets read 0. The two channels are fully independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 4 | Byte address: bit 3 selects the channel, bits 2:0 the offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the addressed register |
| xfer_done | input | 2 | Per-channel pulse: the last transfer of a region has finished |
| tgt_abort | input | 2 | Per-channel target abort pulse |
| mst_abort | input | 2 | Per-channel master abort pulse |
| par_err | input | 2 | Per-channel data parity error pulse |
| dev_irq_in | input | 2 | Per-channel raw device interrupt line, synchronous to clk |
| irq_out | output | 2 | Per-channel interrupt flag output |

## Verification
Directed sequences cover each corner case on its own:

- start followed by the done pulse, and start followed by a stop write, so that the two ways of clearing the active flag are told apart;
- each error source applied alone;
- an error that coincides with its clearing write;
- an interrupt cleared while the line is held high, which separates edge capture from level capture.

A random mix of writes, pulses and line toggles on both channels then runs against a bench model. This mix finds interactions between channels and between simultaneous events that the directed cases miss.

// File: rtl/bmide_pkg.sv
// Shared offsets, bit positions and types for the bus-master status block.
// Assumes byte addressing within an 8-byte group per channel.
package bmide_pkg;
    localparam int GRP_OFS_W = 3;
    localparam logic [GRP_OFS_W-1:0] OFS_CMD  = 3'd0;
    localparam logic [GRP_OFS_W-1:0] OFS_STAT = 3'd2;
    localparam logic [GRP_OFS_W-1:0] OFS_BASE = 3'd4;

    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_CAP0 = 5;
    localparam int ST_CAP1 = 6;

    typedef struct packed {
        logic cmd;
        logic stat;
        logic base;
    } bm_wr_t;
endpackage

// File: rtl/bmide_irq_latch.sv
// Edge-capturing interrupt flag with write-one-to-clear.
// Assumes dev_line is already synchronous to clk. A new edge wins over a clear.
module bmide_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_line,
    input  logic clr,
    output logic flag
);
    logic line_q;
    logic edge_seen;

    assign edge_seen = dev_line & ~line_q;

    // Registered copy of the line, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= dev_line;
    end

    // Flag: set on a rising edge, cleared by software otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (edge_seen) flag <= 1'b1;
        else if (clr)       flag <= 1'b0;
    end

    // R6: a flag that is clear stays clear unless the line rises.
    p_no_level_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(dev_line && !line_q)) |=> !flag);
    // R5: a rising edge sets the flag.
    p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_line && !line_q) |=> flag);
endmodule

// File: rtl/bmide_chan.sv
// One channel's command, status and descriptor base registers.
// Assumes the event pulses last one cycle and are synchronous to clk.
module bmide_chan
    import bmide_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bm_wr_t               wr,
    input  logic [DW-1:0]        wdata,
    input  logic [GRP_OFS_W-1:0] rd_ofs,
    output logic [DW-1:0]        rdata,
    input  logic                 xfer_done,
    input  logic                 tgt_abort,
    input  logic                 mst_abort,
    input  logic                 par_err,
    input  logic                 dev_line,
    output logic                 irq_flag
);
    logic          cmd_q;
    logic          act_q;
    logic          err_q;
    logic [1:0]    cap_q;
    logic [DW-3:0] base_q;
    logic          err_any;
    logic [7:0]    stat_byte;

    assign err_any = tgt_abort | mst_abort | par_err;

    // Start/stop command bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= 1'b0;
        else if (wr.cmd) cmd_q <= wdata[0];
    end

    // Active flag: set by a start write, cleared by a stop write or region done.
    always_ff @(posedge clk) begin
        if (!rst_n)                       act_q <= 1'b0;
        else if (wr.cmd && wdata[0])      act_q <= 1'b1;
        else if (wr.cmd || xfer_done)     act_q <= 1'b0;
    end

    // Error flag: a new error wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        err_q <= 1'b0;
        else if (err_any)                  err_q <= 1'b1;
        else if (wr.stat && wdata[ST_ERR]) err_q <= 1'b0;
    end

    // Capability storage bits and descriptor base pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            base_q <= '0;
        end else begin
            if (wr.stat) cap_q  <= wdata[ST_CAP1:ST_CAP0];
            if (wr.base) base_q <= wdata[DW-1:2];
        end
    end

    bmide_irq_latch u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_line (dev_line),
        .clr      (wr.stat && wdata[ST_IRQ]),
        .flag     (irq_flag)
    );

    assign stat_byte = {1'b0, cap_q, 2'b00, irq_flag, err_q, act_q};

    // Read mux over the channel's three registers.
    always_comb begin
        unique case (rd_ofs)
            OFS_CMD:  rdata = {{(DW-1){1'b0}}, cmd_q};
            OFS_STAT: rdata = {{(DW-8){1'b0}}, stat_byte};
            OFS_BASE: rdata = {base_q, 2'b00};
            default:  rdata = '0;
        endcase
    end

    p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.cmd && wdata[0]) |=> act_q);
    p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !(wr.cmd && wdata[0])) |=> !act_q);
    p_err_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |=> err_q);
    p_zero_write_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.stat && !wdata[ST_ERR] && err_q) |=> err_q);
    p_stat_keeps_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.stat && !wr.cmd && !xfer_done) |=> $stable(act_q));
endmodule

// File: rtl/bmide_status_block.sv
// Two-channel bus-master status block: address decode, channel instances, read select.
// Assumes byte addresses: bits 2:0 give the offset within a group, the upper bits the channel.
module bmide_status_block
    import bmide_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DW     = 32,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = GRP_OFS_W + CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NUM_CH-1:0] xfer_done,
    input  logic [NUM_CH-1:0] tgt_abort,
    input  logic [NUM_CH-1:0] mst_abort,
    input  logic [NUM_CH-1:0] par_err,
    input  logic [NUM_CH-1:0] dev_irq_in,
    output logic [NUM_CH-1:0] irq_out
);
    logic [GRP_OFS_W-1:0] ofs;
    logic [CH_W-1:0]      ch_sel;
    logic [DW-1:0]        ch_rdata [NUM_CH];

    assign ofs    = reg_addr[GRP_OFS_W-1:0];
    assign ch_sel = reg_addr[ADDR_W-1:GRP_OFS_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bm_wr_t wr_c;
        logic   hit;

        // Per-channel write strobes from the decoded address.
        always_comb begin
            hit       = reg_wr && (ch_sel == CH_W'(c));
            wr_c.cmd  = hit && (ofs == OFS_CMD);
            wr_c.stat = hit && (ofs == OFS_STAT);
            wr_c.base = hit && (ofs == OFS_BASE);
        end

        bmide_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_c),
            .wdata     (reg_wdata),
            .rd_ofs    (ofs),
            .rdata     (ch_rdata[c]),
            .xfer_done (xfer_done[c]),
            .tgt_abort (tgt_abort[c]),
            .mst_abort (mst_abort[c]),
            .par_err   (par_err[c]),
            .dev_line  (dev_irq_in[c]),
            .irq_flag  (irq_out[c])
        );
    end

    // Read select by channel; unpopulated channel codes read 0.
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (ch_sel == CH_W'(c)) reg_rdata = ch_rdata[c];
    end

    p_base_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == OFS_BASE) |-> (reg_rdata[1:0] == 2'b00));
    p_stat_fixed_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == OFS_STAT) |-> (reg_rdata[7] == 1'b0 && reg_rdata[4:3] == 2'b00));
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs != OFS_CMD && ofs != OFS_STAT && ofs != OFS_BASE) |-> (reg_rdata == '0));
endmodule

// File: tb/bmide_status_block_bench.sv
module bmide_status_block_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  xfer_done = '0, tgt_abort = '0, mst_abort = '0, par_err = '0;
    logic [1:0]  dev_irq_in = '0;
    logic [1:0]  irq_out;

    int checks = 0;
    int errors = 0;

    // Bench model state per channel.
    logic        m_cmd [2];
    logic        m_act [2];
    logic        m_err [2];
    logic        m_irq [2];
    logic [1:0]  m_cap [2];
    logic [29:0] m_base [2];
    logic        m_lq [2];

    always #5 clk = ~clk;

    bmide_status_block u_bmide_status_block (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
        .tgt_abort(tgt_abort), .mst_abort(mst_abort), .par_err(par_err),
        .dev_irq_in(dev_irq_in), .irq_out(irq_out)
    );

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_cmd[c] = 0; m_act[c] = 0; m_err[c] = 0; m_irq[c] = 0;
            m_cap[c] = 0; m_base[c] = 0; m_lq[c] = 0;
        end
    endtask

    // Next-state model from the requirements, using inputs held across the edge.
    task automatic model_step();
        for (int c = 0; c < 2; c++) begin
            logic hit, wc, ws, wb, ed;
            hit = reg_wr && (reg_addr[3] == c[0]);
            wc = hit && reg_addr[2:0] == 3'd0;
            ws = hit && reg_addr[2:0] == 3'd2;
            wb = hit && reg_addr[2:0] == 3'd4;
            if (wc) m_cmd[c] = reg_wdata[0];
            if (wc && reg_wdata[0]) m_act[c] = 1;
            else if (wc || xfer_done[c]) m_act[c] = 0;
            if (tgt_abort[c] || mst_abort[c] || par_err[c]) m_err[c] = 1;
            else if (ws && reg_wdata[1]) m_err[c] = 0;
            ed = dev_irq_in[c] && !m_lq[c];
            if (ed) m_irq[c] = 1;
            else if (ws && reg_wdata[2]) m_irq[c] = 0;
            m_lq[c] = dev_irq_in[c];
            if (ws) m_cap[c] = reg_wdata[6:5];
            if (wb) m_base[c] = reg_wdata[31:2];
        end
    endtask

    function automatic logic [31:0] exp_stat(int c);
        return {24'd0, 1'b0, m_cap[c], 2'b00, m_irq[c], m_err[c], m_act[c]};
    endfunction

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        reg_wr = 0; xfer_done = 0; tgt_abort = 0; mst_abort = 0; par_err = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_wr = 0; reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        for (int c = 0; c < 2; c++) begin
            rd({c[0], 3'd2}, d); chk({tag, " status"}, d, exp_stat(c));
            rd({c[0], 3'd0}, d); chk({tag, " cmd"}, d, {31'd0, m_cmd[c]});
            rd({c[0], 3'd4}, d); chk({tag, " base"}, d, {m_base[c], 2'b00});
            chk({tag, " irq_out"}, {31'd0, irq_out[c]}, {31'd0, m_irq[c]});
        end
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1");

        // R2 start
        wr(4'h0, 32'h1); tick();
        rd(4'h2, d); chk("R2 active set", d[0], 1);
        // R3 region done clears
        xfer_done[0] = 1; tick();
        rd(4'h2, d); chk("R3 done clears", d[0], 0);
        // R3 stop write clears
        wr(4'h0, 32'h1); tick();
        wr(4'h0, 32'h0); tick();
        rd(4'h2, d); chk("R3 stop clears", d[0], 0);
        // R2 start wins over simultaneous done
        wr(4'h0, 32'h1); xfer_done[0] = 1; tick();
        rd(4'h2, d); chk("R2 start wins", d[0], 1);

        // R4 each error source
        tgt_abort[0] = 1; tick(); rd(4'h2, d); chk("R4 target abort", d[1], 1);
        wr(4'h2, 32'h2); tick(); rd(4'h2, d); chk("R4 w1c", d[1], 0);
        mst_abort[0] = 1; tick(); rd(4'h2, d); chk("R4 master abort", d[1], 1);
        wr(4'h2, 32'h2); tick();
        par_err[0] = 1; tick(); rd(4'h2, d); chk("R4 parity", d[1], 1);
        wr(4'h2, 32'h2); par_err[0] = 1; tick();
        rd(4'h2, d); chk("R4 set wins", d[1], 1);
        // R7 zero write keeps error, status write keeps active
        wr(4'h2, 32'h0); tick(); rd(4'h2, d); chk("R7 zero keeps err", d[1], 1);
        wr(4'h0, 32'h0); tick();
        wr(4'h2, 32'h1); tick(); rd(4'h2, d); chk("R7 act untouched", d[0], 0);

        // R5 edge sets flag, R6 clear while high
        dev_irq_in[0] = 1; tick();
        rd(4'h2, d); chk("R5 edge sets", d[2], 1);
        chk("R5 irq_out", irq_out[0], 1);
        wr(4'h2, 32'h0); tick(); rd(4'h2, d); chk("R7 zero keeps irq", d[2], 1);
        wr(4'h2, 32'h4); tick();
        repeat (3) tick();
        rd(4'h2, d); chk("R6 stays clear while high", d[2], 0);
        chk("R6 irq_out low", irq_out[0], 0);
        dev_irq_in[0] = 0; tick();
        dev_irq_in[0] = 1; tick();
        rd(4'h2, d); chk("R6 new edge", d[2], 1);
        dev_irq_in[0] = 0; tick();

        // R8 capability and fixed bits
        wr(4'h2, 32'hFF); tick();
        rd(4'h2, d); chk("R8 status bits", d & 32'hF8, 32'h60);
        // R9 base
        wr(4'h4, 32'hFFFF_FFFF); tick();
        rd(4'h4, d); chk("R9 base", d, 32'hFFFF_FFFC);
        // R10 secondary channel independence and unmapped offsets
        wr(4'h8, 32'h1); tick();
        wr(4'hC, 32'h1234_5677); tick();
        rd(4'hA, d); chk("R10 secondary active", d[0], 1);
        rd(4'hC, d); chk("R10 secondary base", d, 32'h1234_5674);
        rd(4'h4, d); chk("R10 primary base kept", d, 32'hFFFF_FFFC);
        rd(4'h1, d); chk("R10 unmapped", d, 0);
        rd(4'hF, d); chk("R10 unmapped sec", d, 0);
        check_all("R10");

        // Random mix against the model.
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 5);
            if (op == 1) wr({1'($urandom_range(0, 1)), 3'd0}, $urandom);
            else if (op == 2) wr({1'($urandom_range(0, 1)), 3'd2}, $urandom);
            else if (op == 3) wr({1'($urandom_range(0, 1)), 3'd4}, $urandom);
            for (int c = 0; c < 2; c++) begin
                xfer_done[c] = ($urandom_range(0, 7) == 0);
                tgt_abort[c] = ($urandom_range(0, 15) == 0);
                mst_abort[c] = ($urandom_range(0, 15) == 0);
                par_err[c]   = ($urandom_range(0, 15) == 0);
                if ($urandom_range(0, 3) == 0) dev_irq_in[c] = ~dev_irq_in[c];
            end
            tick();
            if (i % 4 == 0) check_all("R4 R5 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule